// File: doc/BRIEF.md
# Synchronous Receive Sync Hunter

This block is the entry stage of a synchronous serial receiver. A hunt command puts it into a search phase. In that phase every accepted serial bit goes into a sync window, and the most recent bits are compared against a programmed sync pattern. The pattern can be 6 bits, 8 bits, 16 bits, or as wide as the selected character length. The compare value comes from two 8-bit sync registers: the single-character modes use the second register, and the dual mode joins both registers into one 16-bit pattern.

When the window matches, the block leaves the hunt phase and gives a one-cycle sync-detected pulse. Character assembly then starts with the next accepted bit. Each completed character appears on a byte-wide output with a one-cycle valid strobe. The upstream bit recovery logic qualifies each serial bit with a strobe, so idle clock cycles between bits are normal. A later hunt command, such as one issued after a framing loss, drops any partial character and starts the search again from an empty window.

Top module: `sync_hunter`

## Requirements
- R1: While reset is asserted, and after it is released, `hunting` is 1, and `sync_detect` and `char_valid` are 0.
- R2: With `sync_mode` = 0, the sync width is 6 bits. The oldest of the last 6 accepted bits is compared with `sync_b[0]` and the newest with `sync_b[5]`. Bits 7:6 of `sync_b` are ignored.
- R3: With `sync_mode` = 1, the last 8 accepted bits must equal `sync_b`, oldest bit at bit 0. A difference in any one bit, including bit 7, prevents detection.
- R4: With `sync_mode` = 2, the sync width is 16 bits. The pattern is `sync_a` received first (LSB first) followed by `sync_b` (LSB first). `sync_b` received on its own does not match.
- R5: With `sync_mode` = 3, the sync width equals the character length, and the low bits of `sync_b` form the pattern.
- R6: A match counts only after at least N bits (N = the sync width) have been accepted since the block last entered the hunt phase. A hunt command restarts that count.
- R7: The bit that completes a match makes `sync_detect` high for exactly one clock, starting one clock after the edge that accepts it. `hunting` falls at the same time.
- R8: Assembly starts with the first accepted bit after the match. Characters are assembled LSB first. The length code `char_len` 0/1/2/3 selects 5/6/7/8 bits. One clock after the final bit, `char_valid` pulses for one clock and `char_data` holds the character right-aligned with the unused upper bits at 0.
- R9: An `enter_hunt` pulse returns the block to the hunt phase at the next edge from any state. It discards any partial character. A bit accepted in the same cycle as `enter_hunt` is ignored.
- R10: Clock cycles with `bit_valid` low have no effect: `rx_bit` is ignored, `hunting` is unchanged, and the bit count is unchanged.
- R11: Once out of the hunt phase, the block does not search. A data character equal to the sync pattern produces `char_valid` and no `sync_detect`. `hunting` returns to 1 only through `enter_hunt` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_hunt | input | 1 | Return to hunt phase |
| bit_valid | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Serial receive bit |
| sync_mode | input | 2 | 0: 6-bit, 1: 8-bit, 2: 16-bit dual, 3: character-length sync |
| char_len | input | 2 | Character length code, 0..3 gives 5..8 bits |
| sync_a | input | 8 | First sync character (dual mode only) |
| sync_b | input | 8 | Second sync character / single sync character |
| hunting | output | 1 | High while in hunt phase |
| sync_detect | output | 1 | One-cycle pulse on sync match |
| char_valid | output | 1 | One-cycle strobe for a completed character |
| char_data | output | 8 | Last completed character, right-aligned |

## Verification
Every result is registered once after the edge that causes it. `sync_detect` and the fall of `hunting` come one clock after the edge that accepts the completing bit. `char_valid` and `char_data` come one clock after the final bit of a character. `enter_hunt` takes effect at the very next edge. The bench drives each bit at a falling edge and reads the outputs at the following falling edge, which is the exact cycle the result is due. It then holds one idle cycle and confirms that both pulses have already dropped. Detection is checked at an exact bit index within a stream prefixed with zeros, so an early match or a late match both show up as a wrong index.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  localparam int unsigned CHAR_W     = 8;
  localparam int unsigned SYNC_W     = 2 * CHAR_W;
  localparam int unsigned CLEN_W     = $clog2(CHAR_W + 1);
  localparam int unsigned SLEN_W     = $clog2(SYNC_W + 1);
  localparam int unsigned SHORT_SYNC = 6;
  localparam int unsigned MIN_CHAR   = 5;
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic [1:0] {
    SM_SIX     = 2'd0,
    SM_EIGHT   = 2'd1,
    SM_DUAL    = 2'd2,
    SM_CHARLEN = 2'd3
  } sync_mode_e;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_FRAMED = 1'b1
  } hunt_state_e;

  // Character length in bits from its 2-bit code.
  function automatic logic [CLEN_W-1:0] char_bits(input logic [1:0] code);
    return CLEN_W'(MIN_CHAR) + CLEN_W'(code);
  endfunction

  // Sync window width in bits for the active mode.
  function automatic logic [SLEN_W-1:0] sync_bits(input sync_mode_e m,
                                                  input logic [1:0] code);
    logic [SLEN_W-1:0] w;
    case (m)
      SM_SIX:   w = SLEN_W'(SHORT_SYNC);
      SM_EIGHT: w = SLEN_W'(CHAR_W);
      SM_DUAL:  w = SLEN_W'(SYNC_W);
      default:  w = SLEN_W'(char_bits(code));
    endcase
    return w;
  endfunction

  // Compare value: oldest received bit sits at bit 0.
  function automatic logic [SYNC_W-1:0] sync_pattern(input sync_mode_e m,
                                                     input logic [CHAR_W-1:0] first,
                                                     input logic [CHAR_W-1:0] second);
    logic [SYNC_W-1:0] p;
    if (m == SM_DUAL) p = {second, first};
    else              p = {{CHAR_W{1'b0}}, second};
    return p;
  endfunction

endpackage

// File: rtl/sync_hunt_rst_sync.sv
module sync_hunt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = pipe_q[STAGES-1];

endmodule

// File: rtl/sync_hunt_window.sv
module sync_hunt_window
  import sync_hunt_pkg::*;
#(
  parameter int unsigned WIN_W = SYNC_W,
  parameter int unsigned LEN_W = SLEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [LEN_W-1:0] len,
  input  logic [WIN_W-1:0] pattern,
  output logic             match
);

  localparam logic [LEN_W-1:0] FULL = LEN_W'(WIN_W);

  logic [WIN_W-1:0] win_q, win_d, shifted, aligned, mask;
  logic [LEN_W-1:0] fill_q, fill_d, gap;
  logic             enough, upd_en;

  // Newest bit enters at the top, so the oldest of the last N bits lands at bit 0 after alignment.
  always_comb begin
    shifted = {bit_in, win_q[WIN_W-1:1]};
    gap     = FULL - len;
    mask    = {WIN_W{1'b1}} >> gap;
    aligned = shifted >> gap;
    enough  = (fill_q + LEN_W'(1)) >= len;
    match   = shift_en && !clr && enough && ((aligned & mask) == (pattern & mask));
  end

  always_comb begin
    upd_en = clr || shift_en;
    win_d  = win_q;
    fill_d = fill_q;
    if (clr) begin
      win_d  = '0;
      fill_d = '0;
    end else if (shift_en) begin
      win_d = shifted;
      if (fill_q < FULL) fill_d = fill_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (upd_en) begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/sync_hunt_char.sv
module sync_hunt_char
  import sync_hunt_pkg::*;
#(
  parameter int unsigned DATA_W = CHAR_W,
  parameter int unsigned CNT_W  = CLEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic [CNT_W-1:0]  len,
  output logic [DATA_W-1:0] data,
  output logic              valid
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] acc_q, acc_d, acc_next, data_q, data_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              valid_q, valid_d, done, upd_en;

  always_comb begin
    acc_next = {bit_in, acc_q[DATA_W-1:1]};
    cnt_inc  = cnt_q + CNT_W'(1);
    done     = shift_en && !clr && (cnt_inc == len);
  end

  always_comb begin
    upd_en  = clr || shift_en || valid_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (shift_en) begin
      acc_d = acc_next;
      cnt_d = done ? '0 : cnt_inc;
      if (done) begin
        data_d  = acc_next >> (FULL - len);
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (upd_en) begin
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

endmodule

// File: rtl/sync_hunt_ctrl.sv
module sync_hunt_ctrl
  import sync_hunt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter_hunt,
  input  logic match,
  output logic hunting,
  output logic detect
);

  hunt_state_e state_q, state_d;
  logic        detect_q, detect_d;

  always_comb begin
    state_d  = state_q;
    detect_d = 1'b0;
    if (enter_hunt) begin
      state_d = ST_HUNT;
    end else if (state_q == ST_HUNT && match) begin
      state_d  = ST_FRAMED;
      detect_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      detect_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      detect_q <= detect_d;
    end
  end

  assign hunting = (state_q == ST_HUNT);
  assign detect  = detect_q;

endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
  import sync_hunt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_hunt,
  input  logic              bit_valid,
  input  logic              rx_bit,
  input  logic [1:0]        sync_mode,
  input  logic [1:0]        char_len,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  output logic              hunting,
  output logic              sync_detect,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data
);

  logic              rst_core_n;
  sync_mode_e        mode_e;
  logic [CLEN_W-1:0] clen;
  logic [SLEN_W-1:0] slen;
  logic [SYNC_W-1:0] pattern;
  logic              win_shift, win_match, chr_shift, chr_clr;

  sync_hunt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_core_n)
  );

  always_comb begin
    mode_e    = sync_mode_e'(sync_mode);
    clen      = char_bits(char_len);
    slen      = sync_bits(mode_e, char_len);
    pattern   = sync_pattern(mode_e, sync_a, sync_b);
    win_shift = bit_valid && hunting && !enter_hunt;
    chr_clr   = enter_hunt || hunting;
    chr_shift = bit_valid && !hunting && !enter_hunt;
  end

  sync_hunt_window #(.WIN_W(SYNC_W), .LEN_W(SLEN_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (enter_hunt),
    .shift_en (win_shift),
    .bit_in   (rx_bit),
    .len      (slen),
    .pattern  (pattern),
    .match    (win_match)
  );

  sync_hunt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .enter_hunt (enter_hunt),
    .match      (win_match),
    .hunting    (hunting),
    .detect     (sync_detect)
  );

  sync_hunt_char #(.DATA_W(CHAR_W), .CNT_W(CLEN_W)) u_char (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (chr_clr),
    .shift_en (chr_shift),
    .bit_in   (rx_bit),
    .len      (clen),
    .data     (char_data),
    .valid    (char_valid)
  );

endmodule

// File: rtl/sync_hunter_checker.sv
module sync_hunter_checker (
  input logic clk,
  input logic rst_n,
  input logic enter_hunt,
  input logic bit_valid,
  input logic hunting,
  input logic sync_detect,
  input logic char_valid
);

  assert_detect_leaves_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_detect |-> (!hunting && $past(hunting)));

  assert_detect_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_detect |=> !sync_detect);

  assert_abort_to_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hunt |=> (hunting && !sync_detect && !char_valid));

  assert_char_only_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> (!hunting && $past(bit_valid)));

  assert_idle_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_valid) && !$past(enter_hunt)) |-> ($stable(hunting) && !sync_detect && !char_valid));

  assert_stay_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hunting && !enter_hunt) |=> !hunting);

endmodule

bind sync_hunter sync_hunter_checker u_checker (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .enter_hunt  (enter_hunt),
  .bit_valid   (bit_valid),
  .hunting     (hunting),
  .sync_detect (sync_detect),
  .char_valid  (char_valid)
);

// File: tb/sync_hunter_tb.sv
`timescale 1ns/1ps
module sync_hunter_tb;

  logic       clk, rst_n, enter_hunt, bit_valid, rx_bit;
  logic [1:0] sync_mode, char_len;
  logic [7:0] sync_a, sync_b;
  logic       hunting, sync_detect, char_valid;
  logic [7:0] char_data;

  int total, failed;
  int sd_n, cv_n, bit_idx, sd_idx, stretch_err;
  logic [7:0] cv_data;
  bit done;

  sync_hunter u_dut (
    .clk(clk), .rst_n(rst_n), .enter_hunt(enter_hunt), .bit_valid(bit_valid),
    .rx_bit(rx_bit), .sync_mode(sync_mode), .char_len(char_len),
    .sync_a(sync_a), .sync_b(sync_b), .hunting(hunting),
    .sync_detect(sync_detect), .char_valid(char_valid), .char_data(char_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_obs();
    sd_n = 0; cv_n = 0; bit_idx = 0; sd_idx = -1; cv_data = 8'h00;
  endtask

  // One bit cycle followed by one idle cycle; outputs are read where they are due.
  task automatic send_bit(input logic b);
    bit_valid = 1'b1; rx_bit = b;
    @(negedge clk);
    bit_valid = 1'b0;
    bit_idx++;
    if (sync_detect) begin sd_n++; sd_idx = bit_idx; end
    if (char_valid)  begin cv_n++; cv_data = char_data; end
    @(negedge clk);
    if (sync_detect || char_valid) stretch_err++;
  endtask

  task automatic send_word(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bit_valid = 1'b0; rx_bit = ~rx_bit;
      @(negedge clk);
      if (sync_detect) sd_n++;
      if (char_valid)  cv_n++;
    end
  endtask

  task automatic hunt();
    enter_hunt = 1'b1;
    @(negedge clk);
    enter_hunt = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [1:0] cl,
                         input logic [7:0] a, input logic [7:0] b);
    sync_mode = m; char_len = cl; sync_a = a; sync_b = b;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 hunting in reset", int'(hunting), 1);
    chk("R1 sync_detect in reset", int'(sync_detect), 0);
    chk("R1 char_valid in reset", int'(char_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 hunting after release", int'(hunting), 1);
    chk("R1 no pulses after release", int'(sync_detect | char_valid), 0);
  endtask

  task automatic t_six();
    set_cfg(2'd0, 2'd3, 8'h00, 8'hED);
    hunt(); clr_obs();
    send_word(16'h0000, 4);
    send_word(16'h002D, 6);
    chk("R2 six-bit detect count", sd_n, 1);
    chk("R2 six-bit detect index", sd_idx, 10);
    chk("R7 hunting low after detect", int'(hunting), 0);
    clr_obs();
    send_word(16'h00A5, 8);
    chk("R8 eight-bit char count", cv_n, 1);
    chk("R8 eight-bit char data", int'(cv_data), 8'hA5);
  endtask

  task automatic t_eight();
    set_cfg(2'd1, 2'd0, 8'h00, 8'h4B);
    hunt(); clr_obs();
    send_word(16'h0000, 8);
    send_word(16'h00CB, 8);
    chk("R3 bit7 mismatch no detect", sd_n, 0);
    hunt(); clr_obs();
    send_word(16'h0000, 8);
    send_word(16'h004B, 8);
    chk("R3 eight-bit detect index", sd_idx, 16);
    clr_obs();
    send_word(16'h0016, 5);
    chk("R8 five-bit char count", cv_n, 1);
    chk("R8 five-bit char data", int'(cv_data), 8'h16);
  endtask

  task automatic t_dual();
    set_cfg(2'd2, 2'd3, 8'h35, 8'h96);
    hunt(); clr_obs();
    send_word(16'h0000, 16);
    send_word(16'h0096, 8);
    send_word(16'h0000, 8);
    chk("R4 second char alone no detect", sd_n, 0);
    hunt(); clr_obs();
    send_word(16'h0000, 16);
    send_word(16'h9635, 16);
    chk("R4 dual detect count", sd_n, 1);
    chk("R4 dual detect index", sd_idx, 32);
  endtask

  task automatic t_charlen();
    set_cfg(2'd3, 2'd2, 8'h00, 8'hD5);
    hunt(); clr_obs();
    send_word(16'h0000, 7);
    send_word(16'h0055, 7);
    chk("R5 length-mode detect index", sd_idx, 14);
    clr_obs();
    send_word(16'h003C, 7);
    chk("R8 seven-bit char count", cv_n, 1);
    chk("R8 seven-bit char right-aligned", int'(char_data), 8'h3C);
  endtask

  task automatic t_fill();
    set_cfg(2'd1, 2'd3, 8'h00, 8'h00);
    hunt(); clr_obs();
    send_word(16'h0000, 7);
    chk("R6 no detect before full window", sd_n, 0);
    send_bit(1'b0);
    chk("R6 detect at full window", sd_idx, 8);
    hunt(); clr_obs();
    send_word(16'h0000, 5);
    hunt();
    send_word(16'h0000, 7);
    chk("R6 hunt restarts count", sd_n, 0);
    send_bit(1'b0);
    chk("R6 detect after restart", sd_idx, 13);
  endtask

  task automatic t_abort();
    set_cfg(2'd1, 2'd3, 8'h00, 8'h00);
    send_word(16'h0007, 3);
    hunt();
    chk("R9 hunting after abort", int'(hunting), 1);
    clr_obs();
    send_word(16'h0000, 8);
    send_word(16'h005A, 8);
    chk("R9 partial char discarded", int'(cv_data), 8'h5A);
    chk("R9 one char after resync", cv_n, 1);
    enter_hunt = 1'b1; bit_valid = 1'b1; rx_bit = 1'b0;
    @(negedge clk);
    enter_hunt = 1'b0; bit_valid = 1'b0;
    clr_obs();
    send_word(16'h0000, 7);
    chk("R9 same-cycle bit ignored", sd_n, 0);
    send_bit(1'b0);
    chk("R9 detect after eight more", sd_n, 1);
  endtask

  task automatic t_idle();
    set_cfg(2'd1, 2'd3, 8'h00, 8'h00);
    hunt(); clr_obs();
    idle(12);
    chk("R10 idle keeps hunting", int'(hunting), 1);
    chk("R10 idle no detect", sd_n, 0);
    send_word(16'h0000, 8);
    chk("R10 idle bits not counted", sd_idx, 8);
    clr_obs();
    send_word(16'h0009, 4);
    idle(6);
    send_word(16'h0006, 4);
    chk("R10 idle inside char", int'(cv_data), 8'h69);
    chk("R10 single char", cv_n, 1);
  endtask

  task automatic t_framed_data();
    set_cfg(2'd1, 2'd3, 8'h00, 8'h4B);
    hunt(); clr_obs();
    send_word(16'h0000, 8);
    send_word(16'h004B, 8);
    clr_obs();
    send_word(16'h004B, 8);
    chk("R11 sync-valued data no detect", sd_n, 0);
    chk("R11 sync-valued data delivered", int'(cv_data), 8'h4B);
    chk("R11 still framed", int'(hunting), 0);
  endtask

  initial begin
    rst_n = 1'b0; enter_hunt = 1'b0; bit_valid = 1'b0; rx_bit = 1'b0;
    sync_mode = 2'd0; char_len = 2'd3; sync_a = 8'h00; sync_b = 8'h00;
    total = 0; failed = 0; stretch_err = 0; done = 1'b0;
    clr_obs();
    t_reset();
    t_six();
    t_eight();
    t_dual();
    t_charlen();
    t_fill();
    t_abort();
    t_idle();
    t_framed_data();
    chk("R7 pulses last one cycle", stretch_err, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule